// File: doc/BRIEF.md
# Buffered Serial Transmitter with Line Break

The block sends bytes as asynchronous serial frames. Software writes a byte into a holding register. When the frame shifter is free and a bit-period boundary arrives, the byte moves into the shifter. At that same moment a data-empty flag rises, which tells software it may write the next byte. Writes are always accepted. A write made before the previous byte has moved into the shifter replaces that byte, so the earlier byte is never sent.

The bit period is set by a runtime divisor input: one bit lasts `baud_div + 1` clock cycles. Each frame is one low start bit, the data bits least significant first, an optional even parity bit, and one high stop bit. The line rests high between frames.

The pin stage can pass the serial line to the pin, or drive the pin from a port data bit and a port direction bit. Software sends a line break by setting the port data bit low and then switching the pin to port mode. The block leaves reset in standby. Until standby is cleared, all register writes except the standby write are dropped and the bit clock does not run.

Top module: `sertx_top`

## Requirements
- R1: After reset, `tx_empty` = 1, `tx_end` = 1, `txd_o` = 1 and `txd_oe` = 1, and the block is in standby.
- R2: While the standby bit (address 4, bit 0, reset value 1) is 1, writes to addresses 0 to 3 are ignored and no frame is sent. Writing 0 to address 4 is always accepted and starts operation.
- R3: A write to the data register (address 0) clears `tx_empty` at the next clock edge. `tx_empty` rises again on the edge where the byte enters the shifter. On that same edge `txd_o` goes low for the start bit.
- R4: A frame is a start bit (0), DATA_W data bits sent least significant bit first, and a stop bit (1). Each bit lasts `baud_div + 1` cycles.
- R5: When the parity-enable bit (address 1, bit 0) is 1, an even parity bit follows the data bits. The parity bit makes the number of ones across the data bits and the parity bit even.
- R6: A second data write while `tx_empty` = 0 replaces the pending byte. Only the newer byte is sent.
- R7: A byte that is waiting when a frame's stop bit ends starts its own start bit right away. The two start bits are exactly one frame length apart.
- R8: `tx_end` is 1 exactly when `tx_empty` is 1 and no frame is in progress. While `tx_end` is 1 in serial mode, `txd_o` is 1.
- R9: When pin select (address 3, bit 0) is 1, `txd_o` follows the port data bit (address 2, bit 0) and `txd_oe` follows the port direction bit (address 2, bit 1).
- R10: The port data bit and the port direction bit both reset to 1. Switching to port mode without writing them first gives `txd_o` = 1 and `txd_oe` = 1.
- R11: Writing the port data bit to 0 while in serial mode leaves `txd_o` unchanged. Switching the pin select to 1 afterwards holds `txd_o` low, and it stays low until the select returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 data, 1 control, 2 port, 3 pin select, 4 standby) |
| wr_data | input | DATA_W | Write data |
| baud_div | input | DIV_W | Bit period minus one, in clock cycles |
| tx_empty | output | 1 | Data register empty flag |
| tx_end | output | 1 | Data register empty and shifter idle |
| txd_o | output | 1 | Serial pin level |
| txd_oe | output | 1 | Serial pin output enable |

## Verification
The bench uses the default widths: 8 data bits and a 16-bit divisor. It first sends frames with `baud_div` = 4, so each bit lasts five cycles. This leaves room for a write while a frame is in progress, which reaches the overwrite and back-to-back cases. It then sets `baud_div` to 1, two cycles per bit, to confirm that the frame layout holds at a different rate. A byte with an odd number of ones and a byte with an even number of ones are sent with parity enabled, so both parity values appear on the line.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  typedef enum logic [2:0] {
    RA_DATA = 3'd0,
    RA_CTRL = 3'd1,
    RA_PORT = 3'd2,
    RA_PSEL = 3'd3,
    RA_STBY = 3'd4
  } reg_addr_e;

  typedef struct packed {
    logic sel;
    logic dir;
    logic dr;
  } pin_cfg_t;

endpackage

// File: rtl/sertx_baud.sv
module sertx_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q >= div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              run,
  input  logic              wr_data_ev,
  input  logic [DATA_W-1:0] wr_byte,
  input  logic              par_en,
  output logic              tde,
  output logic              busy,
  output logic              load_ev,
  output logic              ser_line
);
  localparam int FW = DATA_W + 3;
  localparam int CW = $clog2(FW + 1);

  function automatic logic [FW-1:0] make_frame(logic [DATA_W-1:0] d, logic pe);
    logic pbit;
    pbit = pe ? ^d : 1'b1;
    return {1'b1, pbit, d, 1'b0};
  endfunction

  function automatic logic [CW-1:0] frame_last(logic pe);
    return pe ? CW'(FW - 1) : CW'(FW - 2);
  endfunction

  logic [DATA_W-1:0] hold_q;
  logic [FW-1:0]     sh_q;
  logic [CW-1:0]     idx_q, last_q;
  logic              busy_q, tde_q;
  logic              at_last, free, done_ev;

  assign at_last = busy_q && (idx_q == last_q);
  assign free    = !busy_q || at_last;
  assign load_ev = tick && run && free && !tde_q;
  assign done_ev = tick && at_last && !load_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      sh_q   <= '1;
      idx_q  <= '0;
      last_q <= '0;
      busy_q <= 1'b0;
      tde_q  <= 1'b1;
    end else begin
      if (wr_data_ev) hold_q <= wr_byte;
      if (load_ev) begin
        sh_q   <= make_frame(hold_q, par_en);
        idx_q  <= '0;
        last_q <= frame_last(par_en);
        busy_q <= 1'b1;
      end else if (done_ev) begin
        busy_q <= 1'b0;
        sh_q   <= '1;
      end else if (tick && busy_q) begin
        sh_q  <= {1'b1, sh_q[FW-1:1]};
        idx_q <= idx_q + 1'b1;
      end
      if (wr_data_ev)   tde_q <= 1'b0;
      else if (load_ev) tde_q <= 1'b1;
    end
  end

  assign tde      = tde_q;
  assign busy     = busy_q;
  assign ser_line = busy_q ? sh_q[0] : 1'b1;
endmodule

// File: rtl/sertx_pinmux.sv
module sertx_pinmux
  import sertx_pkg::*;
(
  input  logic     ser_line,
  input  pin_cfg_t cfg,
  output logic     pin_o,
  output logic     pin_oe
);
  always_comb begin
    if (cfg.sel) begin
      pin_o  = cfg.dr;
      pin_oe = cfg.dir;
    end else begin
      pin_o  = ser_line;
      pin_oe = 1'b1;
    end
  end
endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DIV_W-1:0]  baud_div,
  output logic              tx_empty,
  output logic              tx_end,
  output logic              txd_o,
  output logic              txd_oe
);
  logic     stby_q, par_en_q;
  pin_cfg_t pin_q;
  logic     acc_ok, wr_data_ev, tick, run;
  logic     tde, busy, load_ev, ser_line;

  assign run        = !stby_q;
  assign acc_ok     = wr_en && !stby_q;
  assign wr_data_ev = acc_ok && (wr_addr == RA_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stby_q   <= 1'b1;
      par_en_q <= 1'b0;
      pin_q    <= '{sel: 1'b0, dir: 1'b1, dr: 1'b1};
    end else begin
      if (wr_en && wr_addr == RA_STBY) stby_q <= wr_data[0];
      if (acc_ok && wr_addr == RA_CTRL) par_en_q <= wr_data[0];
      if (acc_ok && wr_addr == RA_PORT) begin
        pin_q.dr  <= wr_data[0];
        pin_q.dir <= wr_data[1];
      end
      if (acc_ok && wr_addr == RA_PSEL) pin_q.sel <= wr_data[0];
    end
  end

  sertx_baud #(.DIV_W(DIV_W)) i_baud (
    .clk(clk), .rst_n(rst_n), .run(run), .div(baud_div), .tick(tick)
  );

  sertx_shift #(.DATA_W(DATA_W)) i_shift (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(run),
    .wr_data_ev(wr_data_ev), .wr_byte(wr_data), .par_en(par_en_q),
    .tde(tde), .busy(busy), .load_ev(load_ev), .ser_line(ser_line)
  );

  sertx_pinmux i_pinmux (
    .ser_line(ser_line), .cfg(pin_q), .pin_o(txd_o), .pin_oe(txd_oe)
  );

  assign tx_empty = tde;
  assign tx_end   = tde && !busy;
endmodule

// File: rtl/sertx_chk.sv
module sertx_chk (
  input logic clk,
  input logic rst_n,
  input logic tde,
  input logic busy,
  input logic tend,
  input logic load_ev,
  input logic wr_data_ev,
  input logic stby,
  input logic tick,
  input logic ser_line,
  input logic psel,
  input logic port_dr,
  input logic txd_o
);
  assert_write_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data_ev |=> !tde);
  assert_load_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_ev && !wr_data_ev) |=> tde);
  assert_start_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> (busy && !ser_line));
  assert_stby_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stby |=> ($stable(tde) && $stable(busy)));
  assert_no_tick_stby_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> !stby);
  assert_idle_mark_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tend && !psel) |-> txd_o);
  assert_port_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && $past(psel) && $stable(port_dr)) |-> $stable(txd_o));
endmodule

bind sertx_top sertx_chk i_chk (
  .clk(clk), .rst_n(rst_n), .tde(tde), .busy(busy), .tend(tx_end),
  .load_ev(load_ev), .wr_data_ev(wr_data_ev), .stby(stby_q), .tick(tick),
  .ser_line(ser_line), .psel(pin_q.sel), .port_dr(pin_q.dr), .txd_o(txd_o)
);

// File: tb/test_sertx_top.sv
module test_sertx_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [15:0] baud_div = 16'd4;
  logic        tx_empty, tx_end, txd_o, txd_oe;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int frames = 0;
  int per = 5;
  bit exp_par = 1'b0;
  bit mon_en = 1'b1;
  logic [7:0] expq[$];
  int starts[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sertx_top i_sertx_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .baud_div(baud_div), .tx_empty(tx_empty),
    .tx_end(tx_end), .txd_o(txd_o), .txd_oe(txd_oe)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic send(logic [7:0] d);
    expq.push_back(d);
    wr(3'd0, d);
  endtask

  task automatic wait_empty();
    int n = 0;
    while (!tx_empty && n < 2000) begin @(negedge clk); n++; end
  endtask

  task automatic wait_end();
    int n = 0;
    while (!tx_end && n < 4000) begin @(negedge clk); n++; end
  endtask

  // monitor: decodes frames on the line and compares them with the queue
  initial begin
    forever begin
      @(negedge clk);
      if (mon_en && rst_n && txd_o == 1'b0) begin
        logic [7:0] got;
        logic st, pb, sp, stp;
        logic [7:0] e;
        starts.push_back(cyc);
        repeat (per / 2) @(negedge clk);
        st = txd_o;
        for (int k = 0; k < 8; k++) begin
          repeat (per) @(negedge clk);
          got[k] = txd_o;
        end
        pb = ^got;
        if (exp_par) begin
          repeat (per) @(negedge clk);
          sp = txd_o;
        end else sp = pb;
        repeat (per) @(negedge clk);
        stp = txd_o;
        frames++;
        if (expq.size() == 0) begin
          chk(1'b0, "R6 unexpected frame", got, 0);
        end else begin
          e = expq.pop_front();
          chk(st == 1'b0 && got == e && sp == pb && stp == 1'b1,
              exp_par ? "R5 frame" : "R4 frame",
              {st, sp, stp, got}, {3'b001, e});
        end
      end
    end
  end

  initial begin
    int sz;
    repeat (3) @(negedge clk);
    chk(tx_empty == 1 && tx_end == 1 && txd_o == 1 && txd_oe == 1, "R1 reset",
        {tx_empty, tx_end, txd_o, txd_oe}, 4'hf);
    rst_n = 1'b1;
    // R2: writes in standby are dropped
    wr(3'd0, 8'h55);
    wr(3'd2, 8'h02);
    wr(3'd3, 8'h01);
    repeat (40) @(negedge clk);
    chk(tx_empty == 1 && txd_o == 1 && frames == 0, "R2 standby",
        {tx_empty, txd_o}, 2'b11);
    wr(3'd4, 8'h00);
    repeat (40) @(negedge clk);
    chk(tx_empty == 1 && txd_o == 1 && frames == 0, "R2 dropped data",
        {tx_empty, txd_o}, 2'b11);

    // R3 / R8 single frame
    send(8'hA5);
    chk(tx_empty == 0, "R3 write clears", tx_empty, 0);
    chk(tx_end == 0, "R8 pending", tx_end, 0);
    wait_empty();
    chk(txd_o == 0, "R3 start on load", txd_o, 0);
    chk(tx_end == 0, "R8 busy", tx_end, 0);
    wait_end();
    chk(txd_o == 1 && frames == 1, "R8 idle mark", {txd_o, frames[3:0]}, 5'h11);

    // R7 back to back
    repeat (7) @(negedge clk);
    sz = starts.size();
    send(8'h3C);
    wait_empty();
    send(8'hC3);
    wait_end();
    repeat (3) @(negedge clk);
    chk(starts.size() == sz + 2 && starts[sz+1] - starts[sz] == 10 * per,
        "R7 gap", starts[sz+1] - starts[sz], 10 * per);

    // R6 overwrite
    send(8'h11);
    wait_empty();
    wr(3'd0, 8'h22);
    send(8'h33);
    wait_end();
    repeat (3) @(negedge clk);
    chk(expq.size() == 0 && frames == 5, "R6 overwrite", frames, 5);

    // R5 parity
    wr(3'd1, 8'h01);
    exp_par = 1'b1;
    send(8'h07);
    wait_end();
    send(8'h03);
    wait_end();
    repeat (3) @(negedge clk);
    wr(3'd1, 8'h00);
    exp_par = 1'b0;

    // R4 other rate
    baud_div = 16'd1;
    per = 2;
    repeat (5) @(negedge clk);
    send(8'hF0);
    wait_end();
    send(8'h81);
    wait_end();
    repeat (3) @(negedge clk);
    chk(expq.size() == 0 && frames == 9, "R4 frame count", frames, 9);

    // R10 / R9 / R11 pin modes
    mon_en = 1'b0;
    wr(3'd3, 8'h01);
    chk(txd_o == 1 && txd_oe == 1, "R10 mark default", {txd_o, txd_oe}, 2'b11);
    wr(3'd2, 8'h01);
    chk(txd_o == 1 && txd_oe == 0, "R9 direction", {txd_o, txd_oe}, 2'b10);
    wr(3'd3, 8'h00);
    wr(3'd2, 8'h02);
    chk(txd_o == 1 && txd_oe == 1, "R11 serial unaffected", {txd_o, txd_oe}, 2'b11);
    wr(3'd3, 8'h01);
    for (int i = 0; i < 20; i++) begin
      if (i % 5 == 0) chk(txd_o == 0 && txd_oe == 1, "R11 break", {txd_o, txd_oe}, 2'b01);
      @(negedge clk);
    end
    chk(txd_o == 0 && txd_oe == 1, "R9 port drive", {txd_o, txd_oe}, 2'b01);
    wr(3'd3, 8'h00);
    chk(txd_o == 1, "R11 release", txd_o, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule